// File: doc/BRIEF.md
# Absolute Encoder Origin Compensation

This block takes the parallel position word of an absolute rotary encoder and turns it into a present value (PV) that has been corrected for an origin offset. A configuration word selects the resolution (8, 10 or 12 bits) and the output form. The output form is either a decimal count in four BCD digits, or an angle from 0 to 359 degrees in three BCD digits.

A single-cycle compensation request sets a flag. When the flag is serviced, the block takes the current raw position, masked to the active resolution, as the new origin. It stores that offset and shows it in BCD, then clears the flag by itself. After that, the PV reads zero until the encoder moves. The offset stays in force through later configuration changes, until the next request replaces it.

A sequential double-dabble engine converts the values to BCD. The block runs conversions back to back, and each new PV is marked with a one-cycle strobe.

Top module: `abs_origin_comp`

## Requirements
- R1: After reset, pv_o, offset_o and comp_flag_o are zero. The configuration is 8-bit resolution in count mode.
- R2: A configuration word is loaded when cfg_we_i is high. Bits [1:0] select the resolution: 0 is 8-bit, 1 is 10-bit, 2 is 12-bit, and 3 is treated as 8-bit. Bits [5:4] select the output form: 1 is degrees, and 0, 2 and 3 are count mode. All other bits are ignored.
- R3: The corrected position is (raw_pos_i − offset) modulo 2^res, where res is the selected resolution in bits.
- R4: In count mode, pv_o holds the corrected position as four BCD digits, with the least significant digit in [3:0].
- R5: In degree mode, pv_o holds floor(corrected × 360 / 2^res) as three BCD digits in [11:0], and [15:12] is zero.
- R6: comp_req_i sets comp_flag_o on the next cycle. Servicing the flag captures the low res bits of raw_pos_i as the offset and clears the flag without any outside action. offset_o then shows that offset as four BCD digits (0000 to 4095) in either mode. The next PV reads 0000 if the encoder has not moved.
- R7: The offset is kept until the next compensation. Writes to the configuration leave it unchanged.
- R8: pv_valid_o is a one-cycle pulse. pv_o changes only in a cycle where pv_valid_o is high.
- R9: A request that arrives while a conversion is in progress is latched. The flag stays high until the conversion in progress ends, and then the request is serviced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_pos_i | input | 12 | Raw position word from the encoder |
| cfg_i | input | 16 | Configuration word |
| cfg_we_i | input | 1 | Loads cfg_i |
| comp_req_i | input | 1 | Origin compensation request pulse |
| comp_flag_o | output | 1 | Compensation pending; clears when serviced |
| offset_o | output | 16 | Stored origin offset, four BCD digits |
| pv_o | output | 16 | Corrected present value, BCD |
| pv_valid_o | output | 1 | One-cycle strobe marking a new pv_o |

## Verification
The following are checked on every cycle:
- pv_valid_o is a single-cycle strobe and pv_o holds steady between strobes.
- Every nibble of pv_o and offset_o is a legal decimal digit, and the offset never exceeds 4095.
- A request raises the flag, and the flag clears within a bounded number of cycles.

The bench's scenarios are the only way to show the following:
- the arithmetic (modular subtraction, degree scaling per resolution, and rounding down at the top of the circle);
- how the configuration word is decoded, including ignored bits and reserved codes;
- that the PV reads zero after compensation;
- that the offset survives configuration changes and that a request made in mid-conversion is kept.

// File: rtl/abs_enc_pkg.sv
package abs_enc_pkg;
  typedef enum logic [1:0] {RES_8 = 2'd0, RES_10 = 2'd1, RES_12 = 2'd2} res_e;
  typedef enum logic {MODE_CNT = 1'b0, MODE_DEG = 1'b1} mode_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} ctl_st_e;
  typedef enum logic {JOB_PV = 1'b0, JOB_OFS = 1'b1} job_e;

  function automatic int res_width(res_e r);
    case (r)
      RES_10:  return 10;
      RES_12:  return 12;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/abs_cfg_decode.sv
module abs_cfg_decode
  import abs_enc_pkg::*;
#(
  parameter int CFG_W = 16
) (
  input  logic [CFG_W-1:0] cfg_i,
  output res_e             res_o,
  output mode_e            mode_o
);
  logic unused_cfg;
  assign unused_cfg = ^{cfg_i[CFG_W-1:6], cfg_i[3:2]};

  // reserved codes fall back to defaults
  assign res_o  = (cfg_i[1:0] == 2'b11) ? RES_8 : res_e'(cfg_i[1:0]);
  assign mode_o = (cfg_i[5:4] == 2'b01) ? MODE_DEG : MODE_CNT;
endmodule

// File: rtl/abs_pos_calc.sv
module abs_pos_calc
  import abs_enc_pkg::*;
#(
  parameter int RAW_W = 12
) (
  input  logic [RAW_W-1:0] raw_i,
  input  logic [RAW_W-1:0] off_i,
  input  res_e             res_i,
  input  mode_e            mode_i,
  output logic [RAW_W-1:0] raw_m_o,
  output logic [RAW_W-1:0] val_o
);
  localparam int DEG_FULL = 360;
  localparam int PROD_W   = RAW_W + $clog2(DEG_FULL);

  logic [RAW_W-1:0]  mask;
  logic [RAW_W-1:0]  diff;
  logic [PROD_W-1:0] prod;

  always_comb begin
    mask    = RAW_W'((1 << res_width(res_i)) - 1);
    raw_m_o = raw_i & mask;
    diff    = (raw_i - off_i) & mask;
    prod    = PROD_W'(diff) * PROD_W'(DEG_FULL);
    val_o   = (mode_i == MODE_DEG) ? RAW_W'(prod >> res_width(res_i)) : diff;
  end
endmodule

// File: rtl/abs_bcd_engine.sv
module abs_bcd_engine #(
  parameter int BIN_W = 12,
  parameter int DIG   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [BIN_W-1:0] bin_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [4*DIG-1:0] bcd_o
);
  localparam int BCD_W = 4 * DIG;
  localparam int CNT_W = $clog2(BIN_W + 1);

  logic [BIN_W-1:0] sh_q;
  logic [BCD_W-1:0] bcd_q, adj;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  for (genvar d = 0; d < DIG; d++) begin : g_adj
    assign adj[4*d +: 4] = (bcd_q[4*d +: 4] > 4'd4) ? bcd_q[4*d +: 4] + 4'd3
                                                     : bcd_q[4*d +: 4];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bcd_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (cnt_q == CNT_W'(1));
      if (cnt_q == '0) begin
        if (start_i) begin
          sh_q  <= bin_i;
          bcd_q <= '0;
          cnt_q <= CNT_W'(BIN_W);
        end
      end else begin
        {bcd_q, sh_q} <= {adj, sh_q} << 1;
        cnt_q         <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = done_q;
  assign bcd_o  = bcd_q;
endmodule

// File: rtl/abs_origin_comp.sv
module abs_origin_comp
  import abs_enc_pkg::*;
#(
  parameter int RAW_W = 12,
  parameter int CFG_W = 16,
  parameter int DIG   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RAW_W-1:0] raw_pos_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             cfg_we_i,
  input  logic             comp_req_i,
  output logic             comp_flag_o,
  output logic [4*DIG-1:0] offset_o,
  output logic [4*DIG-1:0] pv_o,
  output logic             pv_valid_o
);
  localparam int BCD_W = 4 * DIG;

  res_e    res_d, res_q;
  mode_e   mode_d, mode_q;
  ctl_st_e state_q;
  job_e    job_q;
  logic    flag_q;
  logic [RAW_W-1:0] off_bin_q, raw_m, pos_val, eng_bin;
  logic [BCD_W-1:0] off_bcd_q, pv_q, eng_bcd;
  logic    eng_start, eng_busy, eng_done, pv_valid_q;

  abs_cfg_decode #(.CFG_W(CFG_W)) u_dec (
    .cfg_i (cfg_i),
    .res_o (res_d),
    .mode_o(mode_d)
  );

  abs_pos_calc #(.RAW_W(RAW_W)) u_calc (
    .raw_i  (raw_pos_i),
    .off_i  (off_bin_q),
    .res_i  (res_q),
    .mode_i (mode_q),
    .raw_m_o(raw_m),
    .val_o  (pos_val)
  );

  assign eng_start = (state_q == ST_IDLE);
  assign eng_bin   = flag_q ? raw_m : pos_val;

  abs_bcd_engine #(.BIN_W(RAW_W), .DIG(DIG)) u_eng (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(eng_start),
    .bin_i  (eng_bin),
    .busy_o (eng_busy),
    .done_o (eng_done),
    .bcd_o  (eng_bcd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= RES_8;
      mode_q <= MODE_CNT;
    end else if (cfg_we_i) begin
      res_q  <= res_d;
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      job_q      <= JOB_PV;
      flag_q     <= 1'b0;
      off_bin_q  <= '0;
      off_bcd_q  <= '0;
      pv_q       <= '0;
      pv_valid_q <= 1'b0;
    end else begin
      pv_valid_q <= 1'b0;
      // a new request wins over the clear of the one being serviced
      if (comp_req_i) flag_q <= 1'b1;
      else if (state_q == ST_IDLE) flag_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          job_q   <= flag_q ? JOB_OFS : JOB_PV;
          if (flag_q) off_bin_q <= raw_m;
          state_q <= ST_WAIT;
        end
        default: begin
          if (eng_done) begin
            if (job_q == JOB_OFS) begin
              off_bcd_q <= eng_bcd;
            end else begin
              pv_q       <= eng_bcd;
              pv_valid_q <= 1'b1;
            end
            state_q <= ST_IDLE;
          end else if (!eng_busy) begin
            state_q <= ST_WAIT;
          end
        end
      endcase
    end
  end

  assign comp_flag_o = flag_q;
  assign offset_o    = off_bcd_q;
  assign pv_o        = pv_q;
  assign pv_valid_o  = pv_valid_q;
endmodule

// File: rtl/abs_origin_comp_chk.sv
module abs_origin_comp_chk #(
  parameter int DIG = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             comp_req_i,
  input logic             comp_flag_o,
  input logic [4*DIG-1:0] offset_o,
  input logic [4*DIG-1:0] pv_o,
  input logic             pv_valid_o
);
  localparam int FLAG_MAX = 40;

  logic [5:0] flag_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_cnt_q <= '0;
    else if (!comp_flag_o) flag_cnt_q <= '0;
    else if (flag_cnt_q != 6'h3f) flag_cnt_q <= flag_cnt_q + 6'd1;
  end

  a_r8_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv_valid_o |=> !pv_valid_o);

  a_r8_pv_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pv_valid_o |-> $stable(pv_o));

  a_r4_pv_digits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv_o[3:0] <= 4'd9 && pv_o[7:4] <= 4'd9 && pv_o[11:8] <= 4'd9 && pv_o[15:12] <= 4'd9);

  a_r6_offset_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offset_o <= 16'h4095 && offset_o[3:0] <= 4'd9 && offset_o[7:4] <= 4'd9
    && offset_o[11:8] <= 4'd9);

  a_r6_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comp_req_i |=> comp_flag_o);

  a_r9_flag_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_cnt_q < 6'(FLAG_MAX));
endmodule

bind abs_origin_comp abs_origin_comp_chk #(.DIG(DIG)) u_chk (.*);

// File: tb/abs_origin_comp_tb.sv
`timescale 1ns/1ps
module abs_origin_comp_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] raw = '0;
  logic [15:0] cfg = '0;
  logic        cfg_we = 1'b0;
  logic        req = 1'b0;
  logic        flag;
  logic [15:0] offset, pv;
  logic        pv_valid;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // bench model of configuration and offset
  int m_res = 0;
  bit m_deg = 1'b0;
  int m_off = 0;

  always #2.5 clk = ~clk;

  abs_origin_comp u_dut (
    .clk_i(clk), .rst_ni(rst_n), .raw_pos_i(raw), .cfg_i(cfg), .cfg_we_i(cfg_we),
    .comp_req_i(req), .comp_flag_o(flag), .offset_o(offset), .pv_o(pv),
    .pv_valid_o(pv_valid)
  );

  function automatic logic [15:0] to_bcd(int v);
    return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
  endfunction

  function automatic logic [15:0] exp_pv(int r);
    int w = 8 + 2 * m_res;
    int m = (1 << w) - 1;
    int c = (r - m_off) & m;
    return to_bcd(m_deg ? (c * 360) >> w : c);
  endfunction

  task automatic check(string req_id, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req_id, act, exp);
    end
  endtask

  task automatic wait_strobes(int n);
    int got = 0;
    while (got < n) begin
      @(negedge clk);
      if (pv_valid) got++;
    end
  endtask

  task automatic set_cfg(logic [15:0] w);
    @(negedge clk);
    cfg = w; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    m_res = (w[1:0] == 2'b11) ? 0 : int'(w[1:0]);
    m_deg = (w[5:4] == 2'b01);
  endtask

  task automatic set_raw_check(string req_id, logic [11:0] r);
    @(negedge clk);
    raw = r;
    wait_strobes(2);
    check(req_id, pv, exp_pv(int'(r)));
  endtask

  task automatic compensate(string req_id);
    int hi = 0;
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check({req_id, " flag set"}, 16'(flag), 16'd1);
    while (flag && hi < 100) begin
      @(negedge clk);
      hi++;
    end
    check({req_id, " flag self-clear"}, 16'(hi < 40), 16'd1);
    m_off = int'(raw) & ((1 << (8 + 2 * m_res)) - 1);
    wait_strobes(2);
    check({req_id, " offset"}, offset, to_bcd(m_off));
    check({req_id, " pv zero"}, pv, 16'h0000);
  endtask

  task automatic t_reset;
    check("R1 pv", pv, 16'h0000);
    check("R1 offset", offset, 16'h0000);
    check("R1 flag", 16'(flag), 16'd0);
    set_raw_check("R1 default 8-bit count", 12'h1FF);
  endtask

  task automatic t_count_mode;
    set_cfg(16'h0001);
    set_raw_check("R4 10-bit count", 12'hABC);
    set_cfg(16'h0002);
    set_raw_check("R4 12-bit count", 12'hABC);
  endtask

  task automatic t_cfg_decode;
    set_cfg(16'hFFC2);
    set_raw_check("R2 ignored bits", 12'hABC);
    check("R2 ignored bits value", pv, 16'h2748);
    set_cfg(16'h0033);
    set_raw_check("R2 reserved codes", 12'hABC);
    check("R2 reserved codes value", pv, 16'h0188);
  endtask

  task automatic t_degree;
    set_cfg(16'h0010);
    set_raw_check("R5 8-bit half turn", 12'h080);
    check("R5 180 deg", pv, 16'h0180);
    set_cfg(16'h0012);
    set_raw_check("R5 12-bit top", 12'hFFF);
    check("R5 359 deg", pv, 16'h0359);
    set_raw_check("R5 12-bit quarter", 12'h400);
    set_cfg(16'h0011);
    set_raw_check("R5 10-bit", 12'h3FF);
  endtask

  task automatic t_compensation;
    set_cfg(16'h0002);
    @(negedge clk);
    raw = 12'h123;
    wait_strobes(2);
    compensate("R6 count mode");
    set_raw_check("R3 wrap below origin", 12'h100);
    set_cfg(16'h0011);
    wait_strobes(2);
    check("R7 offset kept after cfg write", offset, 16'h0291);
    check("R3 10-bit deg with offset", pv, exp_pv(int'(raw)));
    compensate("R6 degree mode");
  endtask

  task automatic t_latched_req;
    @(negedge clk);
    raw = 12'h2A0;
    wait_strobes(2);
    repeat (3) @(negedge clk);
    compensate("R9 mid-conversion request");
    check("R9 offset value", offset, 16'h0672);
  endtask

  task automatic t_strobe;
    wait_strobes(1);
    begin
      logic [15:0] held = pv;
      raw = 12'h155;
      @(negedge clk);
      check("R8 strobe one cycle", 16'(pv_valid), 16'd0);
      check("R8 pv held between strobes", pv, held);
    end
    wait_strobes(2);
    check("R8 pv after update", pv, exp_pv(int'(raw)));
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    $display("FAIL watchdog actual=%0d expected=<100000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count_mode();
    t_cfg_decode();
    t_degree();
    t_compensation();
    t_latched_req();
    t_strobe();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule